// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory command into the full stream of element addresses that a banked memory needs. A single start pulse carries a base address, an addressing mode and a vector length. From then on the block walks the elements in ascending order with no further control. It presents one address per cycle on a valid/ready request channel, and it labels each address with its element number and with the memory bank it falls in.

Three address patterns are supported. Contiguous mode advances by the element size. Strided mode advances by a signed byte distance. Indexed mode adds a signed per-element offset, which the block reads from an index vector register through a small read port. There is one bank per vector element. The bank number is taken from the address bits just above the element-size offset, so a contiguous, aligned, full-length access touches every bank exactly once.

The block avoids back-to-back requests to one bank while that bank reports itself occupied. In that case it holds the next address back and raises a stall flag. A busy flag covers the whole sequence, and a done pulse marks the acceptance of the final element.

Top module: `vec_addr_gen`

## Requirements
- R1: With mode 0 (contiguous), element i has address base + i * 2^ESZ_LOG, modulo 2^32.
- R2: With mode 1 (strided), element i has address base + i * stride, where stride is signed two's complement and the sum wraps modulo 2^32.
- R3: With mode 2 or 3 (indexed), element i has address base + idx_val. Here idx_val is the signed offset returned while idx_sel equals i, and the sum wraps modulo 2^32.
- R4: Exactly vlen elements are accepted, in ascending order 0, 1, ..., vlen-1, and req_elem carries the element number.
- R5: req_bank equals req_addr bits [ESZ_LOG +: log2(MAX_VL)]. A contiguous run with an aligned base and vlen = MAX_VL uses every bank once.
- R6: done is high for one cycle, in the cycle where element vlen-1 is accepted (req_valid and req_ready both high).
- R7: A start with vlen = 0 issues no address. It raises done for one cycle in the cycle after start, and busy stays low.
- R8: busy rises in the cycle after an accepted start with vlen > 0 and falls in the cycle after done. A start pulse while busy is high has no effect on the running sequence.
- R9: A new address is never presented when its bank equals the bank of the previously presented address and that bank's bank_busy bit was high at the loading edge. stall is high in every cycle where an address is held back for this reason.
- R10: While req_valid is high and req_ready is low, req_valid stays high and req_addr does not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new sequence (ignored while busy) |
| mode | input | 2 | 0 contiguous, 1 strided, 2 or 3 indexed |
| base | input | 32 | Byte base address |
| stride | input | 32 | Signed byte stride for mode 1 |
| vlen | input | log2(MAX_VL)+1 | Number of elements, 0 to MAX_VL |
| idx_sel | output | log2(MAX_VL) | Element number of the index register being read |
| idx_val | input | 32 | Signed offset of element idx_sel, same cycle |
| bank_busy | input | MAX_VL | One occupied flag per memory bank |
| req_valid | output | 1 | An address is presented |
| req_ready | input | 1 | The memory takes the address this cycle |
| req_addr | output | 32 | Element byte address |
| req_bank | output | log2(MAX_VL) | Bank of req_addr |
| req_elem | output | log2(MAX_VL) | Element number of req_addr |
| done | output | 1 | Sequence complete pulse |
| busy | output | 1 | Sequence in progress |
| stall | output | 1 | Next address held back by a bank conflict |

## Verification
The bench builds the block with MAX_VL = 8 and ESZ_LOG = 2. That gives eight banks selected by address bits [4:2], so every vector length from 0 to the maximum can be drawn, and every bank index can be drawn as well. The small bank count makes repeated-bank conflicts frequent under random strides and index offsets. Wrap-around cases, namely negative strides, negative offsets and a base near the top of the address space, are reachable with 32-bit arithmetic.

// File: rtl/vagu_pkg.sv
`timescale 1ns/1ps
package vagu_pkg;
  typedef enum logic [1:0] {
    AM_UNIT    = 2'd0,
    AM_STRIDE  = 2'd1,
    AM_INDEX   = 2'd2,
    AM_INDEX_B = 2'd3
  } amode_e;
endpackage

// File: rtl/vagu_offset.sv
`timescale 1ns/1ps
module vagu_offset
  import vagu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ESZ_LOG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step_en,
  input  amode_e        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [AW-1:0] idx_val,
  output logic [AW-1:0] cand_addr
);
  localparam logic [AW-1:0] USTEP = AW'(1) << ESZ_LOG;

  logic [AW-1:0] off_q;
  logic [AW-1:0] step;

  // running offset replaces an i*stride multiply
  always_comb begin
    step      = (mode == AM_STRIDE) ? stride : USTEP;
    cand_addr = base + (mode[1] ? idx_val : off_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) off_q <= '0;
    else if (step_en) off_q <= off_q + step;
  end

  AST_OFF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> off_q == '0); // R4
endmodule

// File: rtl/vagu_bank.sv
`timescale 1ns/1ps
module vagu_bank #(
  parameter int NBANK = 8,
  localparam int BW = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [BW-1:0]    cand_bank,
  input  logic [NBANK-1:0] bank_busy,
  output logic             conflict
);
  logic [BW-1:0] last_q;
  logic          have_q;

  always_comb conflict = have_q && (cand_bank == last_q) && bank_busy[cand_bank];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (load) begin
      have_q <= 1'b1;
      last_q <= cand_bank;
    end
  end

  AST_HAVE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> have_q && last_q == $past(cand_bank)); // R9
endmodule

// File: rtl/vagu_outreg.sv
`timescale 1ns/1ps
module vagu_outreg #(
  parameter int AW      = 32,
  parameter int BW      = 3,
  parameter int IW      = 3,
  parameter int ESZ_LOG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [BW-1:0] in_bank,
  input  logic [IW-1:0] in_elem,
  input  logic          in_last,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] bank,
  output logic [IW-1:0] elem,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      bank  <= '0;
      elem  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= in_addr;
      bank  <= in_bank;
      elem  <= in_elem;
      last  <= in_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> valid && $stable(addr) && $stable(elem)); // R10
  AST_BANK_FIELD: assert property (@(posedge clk) disable iff (rst)
    valid |-> bank == addr[ESZ_LOG +: BW]); // R5
endmodule

// File: rtl/vec_addr_gen.sv
`timescale 1ns/1ps
module vec_addr_gen
  import vagu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_VL  = 8,
  parameter int ESZ_LOG = 2,
  localparam int NBANK  = MAX_VL,
  localparam int BW     = $clog2(NBANK),
  localparam int IW     = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    stride,
  input  logic [IW:0]      vlen,
  output logic [IW-1:0]    idx_sel,
  input  logic [AW-1:0]    idx_val,
  input  logic [NBANK-1:0] bank_busy,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [BW-1:0]    req_bank,
  output logic [IW-1:0]    req_elem,
  output logic             done,
  output logic             busy,
  output logic             stall
);
  logic          busy_q, zero_q;
  logic [IW:0]   cnt_q, vl_q;
  amode_e        mode_q;
  logic [AW-1:0] base_q, stride_q;

  logic          start_acc, can_gen, space, conflict, load, accept_last, req_last;
  logic [AW-1:0] cand_addr;
  logic [BW-1:0] cand_bank;
  logic          cand_last;

  always_comb begin
    start_acc   = start && !busy_q;
    can_gen     = busy_q && (cnt_q < vl_q);
    space       = !req_valid || req_ready;
    load        = can_gen && space && !conflict;
    stall       = can_gen && space && conflict;
    accept_last = req_valid && req_ready && req_last;
    done        = accept_last || zero_q;
    busy        = busy_q;
    idx_sel     = cnt_q[IW-1:0];
    cand_bank   = cand_addr[ESZ_LOG +: BW];
    cand_last   = (cnt_q == vl_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      zero_q   <= 1'b0;
      cnt_q    <= '0;
      vl_q     <= '0;
      mode_q   <= AM_UNIT;
      base_q   <= '0;
      stride_q <= '0;
    end else begin
      zero_q <= start_acc && (vlen == '0);
      if (start_acc) begin
        busy_q   <= (vlen != '0);
        cnt_q    <= '0;
        vl_q     <= vlen;
        mode_q   <= amode_e'(mode);
        base_q   <= base;
        stride_q <= stride;
      end else begin
        if (load)        cnt_q  <= cnt_q + 1'b1;
        if (accept_last) busy_q <= 1'b0;
      end
    end
  end

  vagu_offset #(.AW(AW), .ESZ_LOG(ESZ_LOG)) u_offset (
    .clk(clk), .rst(rst), .clear(start_acc), .step_en(load), .mode(mode_q),
    .base(base_q), .stride(stride_q), .idx_val(idx_val), .cand_addr(cand_addr)
  );

  vagu_bank #(.NBANK(NBANK)) u_bank (
    .clk(clk), .rst(rst), .clear(start_acc), .load(load),
    .cand_bank(cand_bank), .bank_busy(bank_busy), .conflict(conflict)
  );

  vagu_outreg #(.AW(AW), .BW(BW), .IW(IW), .ESZ_LOG(ESZ_LOG)) u_out (
    .clk(clk), .rst(rst), .load(load), .in_addr(cand_addr), .in_bank(cand_bank),
    .in_elem(cnt_q[IW-1:0]), .in_last(cand_last), .ready(req_ready),
    .valid(req_valid), .addr(req_addr), .bank(req_bank), .elem(req_elem), .last(req_last)
  );

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !done) |=> (!req_valid || req_elem == $past(req_elem) + 1'b1)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> !done); // R6
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> !req_valid && !busy); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done && busy) |=> !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(base_q) && $stable(vl_q) && $stable(mode_q)); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    stall |=> req_valid == ($past(req_valid) && !$past(req_ready))); // R9
endmodule

// File: tb/test_vec_addr_gen.sv
`timescale 1ns/1ps
module test_vec_addr_gen;
  localparam int AW = 32, MAX_VL = 8, ESZ_LOG = 2, NB = 8, BW = 3, IW = 3;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0, req_ready = 1'b0;
  logic [1:0]    mode = '0;
  logic [AW-1:0] base = '0, stride = '0, idx_val;
  logic [IW:0]   vlen = '0;
  logic [IW-1:0] idx_sel, req_elem;
  logic [NB-1:0] bank_busy = '0;
  logic          req_valid, done, busy, stall;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_bank;

  logic [AW-1:0] idx_tab [MAX_VL];
  logic [NB-1:0] seen_banks;
  int checks = 0, bad = 0;

  always #4 clk = ~clk;
  always_comb idx_val = idx_tab[idx_sel];

  vec_addr_gen #(.AW(AW), .MAX_VL(MAX_VL), .ESZ_LOG(ESZ_LOG)) i_vec_addr_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base(base), .stride(stride),
    .vlen(vlen), .idx_sel(idx_sel), .idx_val(idx_val), .bank_busy(bank_busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bank(req_bank), .req_elem(req_elem), .done(done), .busy(busy), .stall(stall)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] b,
                                           input logic [31:0] s, input int i);
    if (m[1])      return b + idx_tab[i];
    else if (m[0]) return b + 32'(i) * s;
    else           return b + (32'(i) << ESZ_LOG);
  endfunction

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL R4 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  task automatic run_vec(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                         input int vl, input int rdy_pct, input int busy_pct, input bit poke);
    int n = 0, guard = 0;
    bit fin = 0, pv = 0, pr = 0, pacc = 0, have = 0;
    logic [31:0] pa = '0;
    logic [BW-1:0] lastb = '0;
    logic [NB-1:0] pbusy = '0;
    seen_banks = '0;
    @(negedge clk);
    start = 1; mode = m; base = b; stride = s; vlen = (IW+1)'(vl); bank_busy = '0; req_ready = 0;
    @(negedge clk);
    start = 0;
    #1;
    if (vl == 0) begin
      check(done == 1'b1, "R7 done after zero-length start", 32'(done), 1);
      check(!req_valid && !busy, "R7 no request, not busy", {30'd0, req_valid, busy}, 0);
      @(negedge clk); #1;
      check(done == 1'b0, "R7 done is one cycle", 32'(done), 0);
      return;
    end
    check(busy == 1'b1, "R8 busy after start", 32'(busy), 1);
    if (poke) begin
      start = 1; base = b ^ 32'h5a5a_0000; mode = ~m; vlen = 1;
    end
    while (!fin && guard < 3000) begin
      req_ready = ($urandom_range(99) < rdy_pct);
      bank_busy = ($urandom_range(99) < busy_pct) ? NB'($urandom) : '0;
      #1;
      if (req_valid && (!pv || pacc)) begin
        if (have && req_bank == lastb && pbusy[req_bank])
          check(0, "R9 same busy bank back to back", 32'(req_bank), 32'(~lastb));
        check(req_bank == req_addr[ESZ_LOG +: BW], "R5 bank field", 32'(req_bank), 32'(req_addr[ESZ_LOG +: BW]));
        have = 1; lastb = req_bank;
      end
      if (pv && !pr)
        check(req_valid && req_addr == pa, "R10 held while not ready", req_addr, pa);
      if (req_valid && req_ready) begin
        check(32'(req_elem) == 32'(n), "R4 element order", 32'(req_elem), 32'(n));
        check(req_addr == exp_addr(m, b, s, n),
              m[1] ? "R3 indexed address" : (m[0] ? "R2 strided address" : "R1 contiguous address"),
              req_addr, exp_addr(m, b, s, n));
        check(done == (n == vl - 1), "R6 done on last accept", 32'(done), 32'(n == vl - 1));
        seen_banks[req_bank] = 1'b1;
        n++;
        if (done) fin = 1;
      end else if (done) begin
        check(0, "R6 done without acceptance", 32'(done), 0);
      end
      pv = req_valid; pr = req_ready; pa = req_addr; pacc = req_valid && req_ready; pbusy = bank_busy;
      @(negedge clk);
      start = 0;
      guard++;
    end
    #1;
    check(!busy, "R8 busy falls after done", 32'(busy), 0);
    check(!done, "R6 single done pulse", 32'(done), 0);
    check(n == vl, "R4 element count", 32'(n), 32'(vl));
    req_ready = 0; bank_busy = '0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MAX_VL; i++) idx_tab[i] = 32'(i * 4);
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(!req_valid && !busy && !done && !stall, "R8 reset state",
          {28'd0, req_valid, busy, done, stall}, 0);

    // directed corners
    run_vec(2'd0, 32'h0000_2000, 0, 8, 100, 0, 0);
    check(seen_banks == 8'hff, "R5 full contiguous run touches all banks", 32'(seen_banks), 32'hff);
    run_vec(2'd0, 32'hffff_fff8, 0, 5, 70, 0, 0);            // R1 wrap
    run_vec(2'd1, 32'h0000_0008, 32'hffff_fff4, 6, 80, 0, 0); // R2 negative stride
    for (int i = 0; i < MAX_VL; i++) idx_tab[i] = 32'(-(i * 20)) + 32'd3;
    run_vec(2'd2, 32'h0000_0010, 0, 8, 60, 30, 0);            // R3 negative offsets
    run_vec(2'd3, 32'h8000_0000, 0, 3, 100, 0, 0);            // R3 mode 3
    run_vec(2'd1, 32'h0000_4000, 32'd64, 8, 30, 0, 1);        // R8 start while busy
    run_vec(2'd0, 32'h0000_1000, 0, 0, 100, 0, 0);            // R7
    run_vec(2'd0, 32'h0000_1000, 0, 1, 100, 0, 0);            // R6 length one

    // R9 directed: all elements on one occupied bank
    @(negedge clk);
    start = 1; mode = 2'd1; base = 32'h100; stride = 0; vlen = 3; bank_busy = '1; req_ready = 1;
    @(negedge clk); start = 0;
    @(negedge clk); #1;
    check(req_valid && req_elem == 0, "R9 first element free", 32'(req_valid), 1);
    @(negedge clk); #1;
    check(!req_valid && stall, "R9 held back, stall high", {30'd0, req_valid, stall}, 1);
    @(negedge clk); #1;
    check(!req_valid && stall, "R9 still held back", {30'd0, req_valid, stall}, 1);
    bank_busy = '0;
    begin
      int got = 0;
      bit sawdone = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk); #1;
        if (req_valid && req_ready) begin
          got++;
          if (done) sawdone = 1;
        end
      end
      check(got == 2 && sawdone, "R9 sequence resumes after release", 32'(got), 2);
    end
    req_ready = 0;

    // constrained random
    for (int v = 0; v < 40; v++) begin
      logic [1:0] m;
      logic [31:0] s;
      m = 2'($urandom_range(3));
      s = ($urandom_range(1) == 1) ? 32'($urandom_range(64)) - 32'd32 : $urandom;
      for (int i = 0; i < MAX_VL; i++)
        idx_tab[i] = ($urandom_range(1) == 1) ? 32'($urandom_range(256)) - 32'd128 : $urandom;
      run_vec(m, $urandom, s, $urandom_range(MAX_VL), 40 + $urandom_range(60),
              $urandom_range(60), $urandom_range(3) == 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule